// File: doc/BRIEF.md
# USB Control Endpoint Status Register

This block holds the status and control flags of a USB device's control endpoint. It sits between a processor register port and the USB transaction engine. The processor reaches it as one indexed 8-bit register with read and write strobes. The engine reports bus events to it on single-cycle pulse inputs: packet received, IN packet sent, IN packet overwritten by SETUP, IN packet overwritten by OUT, STALL handshake sent, control transfer ended early, and status stage complete.

The flags are owned in two ways. The OUT-ready and setup-end flags are raised only by the engine. Firmware clears them by writing 1 to one of two "serviced" strobe bits, and those strobe bits always read back as zero. The IN-ready, send-stall and data-end flags are set by firmware and cleared by the engine when the matching bus event occurs. The sent-stall flag is set by the engine and cleared by firmware writing 0 to it.

The block drives the current stall request, the IN-ready flag and the data-end flag to the engine. It also raises a one-cycle endpoint interrupt pulse when a packet arrives and when a pending IN packet is retired.

Top module: `ep0_ctrl_csr`

## Requirements
- R1: After a synchronous reset the register reads 0x00. Only index 0x11 is decoded: a write at any other index changes nothing, and a read at any other index returns 0x00.
- R2: The register layout is bit7 serviced-setup-end strobe, bit6 serviced-OUT strobe, bit5 send-stall, bit4 setup-end, bit3 data-end, bit2 sent-stall, bit1 IN-ready, bit0 OUT-ready. Bits 7 and 6 always read as 0.
- R3: A packet-received event sets OUT-ready (bit0). Only a write with bit6=1 clears it. Writes to bit0 have no effect.
- R4: Writing 1 to bit1 sets IN-ready. While IN-ready is set, an IN-sent, SETUP-overwrite or OUT-overwrite event clears it. Writing 0 to bit1 has no effect.
- R5: ep_irq pulses high for exactly the one cycle after a packet-received event or after an event that clears a set IN-ready flag. In every other cycle ep_irq is low.
- R6: Writing 1 to bit5 sets send-stall, which drives stall_req. A STALL-sent event clears send-stall. Writing 0 to bit5 has no effect.
- R7: A STALL-sent event sets sent-stall (bit2). A write with bit2=0 clears it. A write with bit2=1 has no effect.
- R8: An early-end event raises setup-end (bit4) only while data-end is 0. A write with bit7=1 clears setup-end. Bit4 itself is not writable.
- R9: Writing 1 to bit3 sets data-end. A status-complete event clears it, and so does the raising of setup-end; when a clear and a software set meet in the same cycle, the clear wins. Writing 0 to bit3 has no effect.
- R10: When a hardware set of OUT-ready, setup-end or sent-stall coincides with the software clear of the same flag, the flag ends up set.
- R11: Every flag change becomes visible on the outputs and in read data in the cycle after the write or event that caused it, not in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (0 when not selected) |
| ev_pkt_rx | input | 1 | OUT/SETUP data packet received |
| ev_in_sent | input | 1 | IN packet transmitted |
| ev_setup_ovw | input | 1 | IN packet overwritten by SETUP |
| ev_out_ovw | input | 1 | IN packet overwritten by OUT |
| ev_stall_sent | input | 1 | STALL handshake transmitted |
| ev_early_end | input | 1 | Control transfer ended early |
| ev_status_done | input | 1 | Status stage complete |
| stall_req | output | 1 | Send-stall flag to the engine |
| in_ready | output | 1 | IN-ready flag to the engine |
| data_end | output | 1 | Data-end flag to the engine |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
The hardest cases to reach from the ports are cycles where an engine event and a processor write land on the same flag in the same cycle. Examples are a packet arrival together with the serviced-OUT strobe, and a STALL-sent event together with a write that clears sent-stall. An early end that arrives while data-end is already set is another such case. Random stimulus fires each event with a fixed probability and mixes in writes of random data, so these overlaps occur many times. Directed steps then force the exact overlaps and check them once on their own.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;

    localparam int CSR_W        = 8;
    localparam int B_SVC_SETUP  = 7;
    localparam int B_SVC_OUT    = 6;
    localparam int B_SEND_STALL = 5;
    localparam int B_SETUP_END  = 4;
    localparam int B_DATA_END   = 3;
    localparam int B_SENT_STALL = 2;
    localparam int B_IN_RDY     = 1;
    localparam int B_OUT_RDY    = 0;

    typedef struct packed {
        logic send_stall;
        logic setup_end;
        logic data_end;
        logic sent_stall;
        logic in_rdy;
        logic out_rdy;
    } ep0_flags_t;

    typedef struct packed {
        logic svc_setup;
        logic svc_out;
        logic set_stall;
        logic set_dend;
        logic clr_sent;
        logic set_in;
    } ep0_cmd_t;

    typedef struct packed {
        logic pkt_rx;
        logic in_sent;
        logic setup_ovw;
        logic out_ovw;
        logic stall_sent;
        logic early_end;
        logic status_done;
    } ep0_evt_t;

    function automatic logic [CSR_W-1:0] ep0_pack(input ep0_flags_t f);
        logic [CSR_W-1:0] v;
        v               = '0;
        v[B_SEND_STALL] = f.send_stall;
        v[B_SETUP_END]  = f.setup_end;
        v[B_DATA_END]   = f.data_end;
        v[B_SENT_STALL] = f.sent_stall;
        v[B_IN_RDY]     = f.in_rdy;
        v[B_OUT_RDY]    = f.out_rdy;
        return v;
    endfunction

    function automatic ep0_cmd_t ep0_decode(input logic [CSR_W-1:0] d, input logic hit);
        ep0_cmd_t c;
        c.svc_setup = hit &  d[B_SVC_SETUP];
        c.svc_out   = hit &  d[B_SVC_OUT];
        c.set_stall = hit &  d[B_SEND_STALL];
        c.set_dend  = hit &  d[B_DATA_END];
        c.clr_sent  = hit & ~d[B_SENT_STALL];
        c.set_in    = hit &  d[B_IN_RDY];
        return c;
    endfunction

endpackage

// File: rtl/ep0_host_dec.sv
module ep0_host_dec
    import ep0_csr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h11
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [CSR_W-1:0]  reg_wdata,
    input  ep0_flags_t        flags,
    output ep0_cmd_t          cmd,
    output logic [CSR_W-1:0]  reg_rdata
);
    logic sel;

    always_comb begin
        sel       = (reg_addr == CSR_ADDR);
        cmd       = ep0_decode(reg_wdata, sel & reg_wr);
        reg_rdata = (sel & reg_rd) ? ep0_pack(flags) : '0;
    end
endmodule

// File: rtl/ep0_hw_set_bit.sv
module ep0_hw_set_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/ep0_sw_set_bit.sv
module ep0_sw_set_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (clr_i) q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
    end
endmodule

// File: rtl/ep0_flag_core.sv
module ep0_flag_core
    import ep0_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ep0_cmd_t   cmd,
    input  ep0_evt_t   evt,
    output ep0_flags_t flags,
    output logic       in_retire
);
    logic setup_end_set;
    logic stall_clr;
    logic dend_clr;

    always_comb begin
        setup_end_set = evt.early_end & ~flags.data_end;
        in_retire     = flags.in_rdy & (evt.in_sent | evt.setup_ovw | evt.out_ovw);
        stall_clr     = flags.send_stall & evt.stall_sent;
        dend_clr      = evt.status_done | setup_end_set;
    end

    ep0_hw_set_bit u_out_rdy (
        .clk(clk), .rst(rst), .set_i(evt.pkt_rx), .clr_i(cmd.svc_out), .q_o(flags.out_rdy)
    );
    ep0_hw_set_bit u_setup_end (
        .clk(clk), .rst(rst), .set_i(setup_end_set), .clr_i(cmd.svc_setup), .q_o(flags.setup_end)
    );
    ep0_hw_set_bit u_sent_stall (
        .clk(clk), .rst(rst), .set_i(evt.stall_sent), .clr_i(cmd.clr_sent), .q_o(flags.sent_stall)
    );
    ep0_sw_set_bit u_in_rdy (
        .clk(clk), .rst(rst), .set_i(cmd.set_in), .clr_i(in_retire), .q_o(flags.in_rdy)
    );
    ep0_sw_set_bit u_send_stall (
        .clk(clk), .rst(rst), .set_i(cmd.set_stall), .clr_i(stall_clr), .q_o(flags.send_stall)
    );
    ep0_sw_set_bit u_data_end (
        .clk(clk), .rst(rst), .set_i(cmd.set_dend), .clr_i(dend_clr), .q_o(flags.data_end)
    );
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen (
    input  logic clk,
    input  logic rst,
    input  logic pkt_rx,
    input  logic in_retire,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pkt_rx | in_retire;
    end
endmodule

// File: rtl/ep0_ctrl_csr.sv
module ep0_ctrl_csr
    import ep0_csr_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              ev_pkt_rx,
    input  logic              ev_in_sent,
    input  logic              ev_setup_ovw,
    input  logic              ev_out_ovw,
    input  logic              ev_stall_sent,
    input  logic              ev_early_end,
    input  logic              ev_status_done,
    output logic              stall_req,
    output logic              in_ready,
    output logic              data_end,
    output logic              ep_irq
);
    ep0_evt_t        evt;
    ep0_cmd_t        cmd;
    ep0_flags_t      flags;
    logic            in_retire;
    logic [CSR_W-1:0] csr_q;

    always_comb begin
        evt.pkt_rx      = ev_pkt_rx;
        evt.in_sent     = ev_in_sent;
        evt.setup_ovw   = ev_setup_ovw;
        evt.out_ovw     = ev_out_ovw;
        evt.stall_sent  = ev_stall_sent;
        evt.early_end   = ev_early_end;
        evt.status_done = ev_status_done;
        csr_q           = ep0_pack(flags);
    end

    ep0_host_dec #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_dec (
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .flags(flags), .cmd(cmd), .reg_rdata(reg_rdata)
    );

    ep0_flag_core u_core (
        .clk(clk), .rst(rst), .cmd(cmd), .evt(evt), .flags(flags), .in_retire(in_retire)
    );

    ep0_irq_gen u_irq (
        .clk(clk), .rst(rst), .pkt_rx(ev_pkt_rx), .in_retire(in_retire), .irq(ep_irq)
    );

    assign stall_req = flags.send_stall;
    assign in_ready  = flags.in_rdy;
    assign data_end  = flags.data_end;
endmodule

// File: rtl/ep0_ctrl_csr_chk.sv
module ep0_ctrl_csr_chk #(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 8'h11
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic [7:0]        csr_q,
    input logic              ev_pkt_rx,
    input logic              ev_in_sent,
    input logic              ev_setup_ovw,
    input logic              ev_out_ovw,
    input logic              ev_stall_sent,
    input logic              ev_early_end,
    input logic              ev_status_done,
    input logic              stall_req,
    input logic              in_ready,
    input logic              data_end,
    input logic              ep_irq
);
    logic hit;
    logic retire;
    assign hit    = reg_wr && (reg_addr == CSR_ADDR);
    assign retire = in_ready && (ev_in_sent || ev_setup_ovw || ev_out_ovw);

    p_strobe_zero_r2: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:6] == 2'b00);
    p_out_set_r3: assert property (@(posedge clk) disable iff (rst)
        ev_pkt_rx |=> csr_q[0]);
    p_out_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ev_pkt_rx && !(hit && reg_wdata[6])) |=> $stable(csr_q[0]));
    p_in_clr_r4: assert property (@(posedge clk) disable iff (rst)
        retire |=> !in_ready);
    p_irq_fire_r5: assert property (@(posedge clk) disable iff (rst)
        (ev_pkt_rx || retire) |=> ep_irq);
    p_irq_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !(ev_pkt_rx || retire) |=> !ep_irq);
    p_stall_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (stall_req && ev_stall_sent) |=> !stall_req);
    p_sent_set_r7: assert property (@(posedge clk) disable iff (rst)
        ev_stall_sent |=> csr_q[2]);
    p_setup_end_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_early_end && !data_end) |=> csr_q[4]);
    p_dend_clr_r9: assert property (@(posedge clk) disable iff (rst)
        ev_status_done |=> !data_end);
endmodule

bind ep0_ctrl_csr ep0_ctrl_csr_chk #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_chk (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .csr_q(csr_q), .ev_pkt_rx(ev_pkt_rx), .ev_in_sent(ev_in_sent),
    .ev_setup_ovw(ev_setup_ovw), .ev_out_ovw(ev_out_ovw), .ev_stall_sent(ev_stall_sent),
    .ev_early_end(ev_early_end), .ev_status_done(ev_status_done), .stall_req(stall_req),
    .in_ready(in_ready), .data_end(data_end), .ep_irq(ep_irq)
);

// File: tb/ep0_ctrl_csr_tb.sv
module ep0_ctrl_csr_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] reg_addr;
    logic       reg_wr, reg_rd;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       ev_pkt_rx, ev_in_sent, ev_setup_ovw, ev_out_ovw;
    logic       ev_stall_sent, ev_early_end, ev_status_done;
    logic       stall_req, in_ready, data_end, ep_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // bench model of the flags
    logic m_out, m_in, m_sent, m_dend, m_sete, m_stall, m_irq;

    always #5 clk = ~clk;

    ep0_ctrl_csr u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_pkt_rx(ev_pkt_rx),
        .ev_in_sent(ev_in_sent), .ev_setup_ovw(ev_setup_ovw), .ev_out_ovw(ev_out_ovw),
        .ev_stall_sent(ev_stall_sent), .ev_early_end(ev_early_end),
        .ev_status_done(ev_status_done), .stall_req(stall_req), .in_ready(in_ready),
        .data_end(data_end), .ep_irq(ep_irq)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic drive_idle_read(input logic [7:0] a);
        reg_addr = a; reg_rd = 1'b1; reg_wr = 1'b0; reg_wdata = 8'h00;
        {ev_pkt_rx, ev_in_sent, ev_setup_ovw, ev_out_ovw,
         ev_stall_sent, ev_early_end, ev_status_done} = '0;
    endtask

    task automatic check_all();
        drive_idle_read(8'h11);
        #1;
        chk("R2 strobes", {6'b0, reg_rdata[7:6]}, 8'h00);
        chk("R3 out_rdy", {7'b0, reg_rdata[0]}, {7'b0, m_out});
        chk("R4 in_rdy bit", {7'b0, reg_rdata[1]}, {7'b0, m_in});
        chk("R4 in_ready pin", {7'b0, in_ready}, {7'b0, m_in});
        chk("R7 sent_stall", {7'b0, reg_rdata[2]}, {7'b0, m_sent});
        chk("R9 data_end", {6'b0, reg_rdata[3], data_end}, {6'b0, m_dend, m_dend});
        chk("R8 setup_end", {7'b0, reg_rdata[4]}, {7'b0, m_sete});
        chk("R6 send_stall", {6'b0, reg_rdata[5], stall_req}, {6'b0, m_stall, m_stall});
        chk("R5 irq", {7'b0, ep_irq}, {7'b0, m_irq});
    endtask

    // ev bits: 0 pkt_rx 1 in_sent 2 setup_ovw 3 out_ovw 4 stall_sent 5 early_end 6 status_done
    task automatic step(input logic [7:0] a, input logic w, input logic [7:0] d, input logic [6:0] ev);
        logic hit, in_clr, sete_set;
        logic n_out, n_in, n_sent, n_dend, n_sete, n_stall;
        check_all();
        reg_addr = a; reg_wr = w; reg_wdata = d; reg_rd = 1'b0;
        {ev_status_done, ev_early_end, ev_stall_sent, ev_out_ovw,
         ev_setup_ovw, ev_in_sent, ev_pkt_rx} = ev;
        hit      = w && (a == 8'h11);
        in_clr   = m_in && (ev[1] || ev[2] || ev[3]);
        sete_set = ev[5] && !m_dend;
        n_out    = ev[0] ? 1'b1 : (hit && d[6]) ? 1'b0 : m_out;
        n_sete   = sete_set ? 1'b1 : (hit && d[7]) ? 1'b0 : m_sete;
        n_sent   = ev[4] ? 1'b1 : (hit && !d[2]) ? 1'b0 : m_sent;
        n_in     = in_clr ? 1'b0 : (hit && d[1]) ? 1'b1 : m_in;
        n_stall  = (m_stall && ev[4]) ? 1'b0 : (hit && d[5]) ? 1'b1 : m_stall;
        n_dend   = (ev[6] || sete_set) ? 1'b0 : (hit && d[3]) ? 1'b1 : m_dend;
        #1;
        chk("R11 no same-cycle change", {6'b0, in_ready, stall_req}, {6'b0, m_in, m_stall});
        @(posedge clk);
        m_out = n_out; m_in = n_in; m_sent = n_sent; m_dend = n_dend;
        m_sete = n_sete; m_stall = n_stall; m_irq = ev[0] || in_clr;
        @(negedge clk);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        seed = $urandom(32'h5eed_1234);
        drive_idle_read(8'h11);
        rst = 1'b1;
        {m_out, m_in, m_sent, m_dend, m_sete, m_stall, m_irq} = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 reset value", reg_rdata, 8'h00);

        // R1: write to another index is ignored, read elsewhere is zero
        step(8'h12, 1'b1, 8'h2A, 7'b0);
        step(8'h11, 1'b1, 8'h0A, 7'b0);
        drive_idle_read(8'h10);
        #1;
        chk("R1 unselected read", reg_rdata, 8'h00);

        // R4/R5: IN-ready retired by SETUP overwrite raises irq
        step(8'h11, 1'b0, 8'h00, 7'b0000100);
        // R9: status done clears data-end
        step(8'h11, 1'b1, 8'h08, 7'b0);
        step(8'h11, 1'b0, 8'h00, 7'b1000000);
        // R8: early end with data-end set does not raise setup-end
        step(8'h11, 1'b1, 8'h08, 7'b0);
        step(8'h11, 1'b0, 8'h00, 7'b0100000);
        step(8'h11, 1'b0, 8'h00, 7'b0100000);
        step(8'h11, 1'b1, 8'h84, 7'b0);
        // R10: packet arrival with serviced-OUT strobe in the same cycle
        step(8'h11, 1'b1, 8'h44, 7'b0000001);
        // R10: STALL sent with sent-stall clear; R6 send-stall retired
        step(8'h11, 1'b1, 8'h24, 7'b0);
        step(8'h11, 1'b1, 8'h00, 7'b0010000);
        // R3: writing bit0 alone does nothing
        step(8'h11, 1'b1, 8'h05, 7'b0);
        step(8'h11, 1'b1, 8'h40, 7'b0);

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] a;
            logic [6:0] ev;
            a = ($urandom % 8 == 0) ? 8'h10 + 8'($urandom % 3) : 8'h11;
            for (int k = 0; k < 7; k++) ev[k] = ($urandom % 6 == 0);
            step(a, ($urandom % 3 == 0), 8'($urandom), ev);
        end
        check_all();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule